// File: doc/BRIEF.md
# Slope-Indexed A/D Sample Corrector

This block corrects a stream of two's-complement A/D converter codes, one code per clock. Each code enters a short window of recent samples. A fixed antisymmetric FIR with derivative weights estimates the slope at the centre of that window. The upper bits of the centre sample and a coarse, clamped version of the slope together select one word from an internal error table. That signed word is added to a copy of the centre sample that has been delayed to line up with the lookup, and the sum saturates to the sample width.

The error table is a synchronous RAM with its own write port, so corrections can be loaded between bursts or while samples are flowing. A bypass input passes the aligned raw sample through unchanged. This is useful for measuring the converter while the table is being calibrated. Producing the table contents is outside this block.

Top module: `lut_adc_corrector`

## Requirements
- R1: While reset is held and after it is released, before any sample is accepted, `out_valid` is 0 and `out_sample` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, four clock edges after the accepting edge (counted inclusively). Results leave in arrival order, and `out_valid` never rises without a matching input.
- R3: The sample window advances only on edges where `in_valid` is high. Idle cycles between samples do not change any result.
- R4: With x0 the newest accepted sample and x4 the oldest in a five-sample window, the slope estimate is D = 2·(x1 − x3) + (x0 − x4). Samples not yet received count as 0.
- R5: The slope index is D shifted arithmetically right by 6 bits, then clamped to the signed range −16..15, and encoded as 5-bit two's complement.
- R6: The table address is 10 bits. Bits 9:5 are bits 11:7 of the centre sample x2. Bits 4:0 are the slope index.
- R7: When bypass is low, the output is x2 plus the table entry, which is read as a signed 8-bit value.
- R8: When `bypass` is high on the edge that forms the output, `out_sample` equals x2.
- R9: A write on an edge stores `wr_data` at `wr_addr`. A lookup made on that same edge returns the previous entry, and lookups on any later edge return the new one.
- R10: The sum saturates: results above 2047 give 2047, and results below −2048 give −2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Signed converter code |
| bypass | input | 1 | Pass the aligned raw sample, skipping correction |
| wr_en | input | 1 | Error table write strobe |
| wr_addr | input | 10 | Error table write address |
| wr_data | input | 8 | Signed correction word to store |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | 12 | Corrected signed sample |

## Verification
The hardest case to reach from the ports is a table write that lands on the same edge as the lookup of one specific sample in flight. The write has to hit the exact address that sample forms from its centre value and its slope. The bench predicts that address from its own window model. It then issues the write either one edge before the lookup or on the lookup edge itself, and expects the new entry or the old one accordingly. Saturation at both rails is reached with constant runs at full scale, where the slope index settles to zero, aimed at entries preloaded with large corrections. Ramps of random step drive the slope index through its whole clamped range.

// File: rtl/ecomp_pkg.sv
package ecomp_pkg;

  // Clamp a signed integer to an inclusive range.
  function automatic int clamp_int(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (v > hi) r = hi;
    if (v < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/ecomp_slope.sv
module ecomp_slope #(
  parameter int DW    = 12,
  parameter int HALF  = 2,
  parameter int AB    = 5,
  parameter int SB    = 5,
  parameter int SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_sample,
  output logic                 lk_valid,
  output logic [AB+SB-1:0]     lk_addr,
  output logic [DW-1:0]        lk_center
);
  import ecomp_pkg::*;

  localparam int NT   = 2*HALF + 1;
  localparam int DDW  = DW + HALF + 2;
  localparam int AW   = AB + SB;
  localparam int SMAX = 2**(SB-1) - 1;
  localparam int SMIN = -(2**(SB-1));

  logic [NT-1:0][DW-1:0] taps_q, taps_d;
  logic                  pend_q;
  logic signed [DDW-1:0] diff_acc, diff_shr;
  logic [SB-1:0]         slope_f;
  logic [AW-1:0]         addr_d;

  // window shift: index 0 newest
  assign taps_d[0] = in_sample;
  for (genvar j = 1; j < NT; j++) begin : g_shift
    assign taps_d[j] = taps_q[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
    end else if (in_valid) begin
      taps_q <= taps_d;
    end
  end

  // antisymmetric derivative weights: 2^(HALF-k) on lag pair k
  always_comb begin
    diff_acc = '0;
    for (int k = 1; k <= HALF; k++) begin
      diff_acc = diff_acc
               + ((DDW'($signed(taps_q[HALF-k])) - DDW'($signed(taps_q[HALF+k])))
                  <<< (HALF-k));
    end
    diff_shr = diff_acc >>> SHIFT;
    slope_f  = SB'(clamp_int(int'(diff_shr), SMIN, SMAX));
    addr_d   = {taps_q[HALF][DW-1 -: AB], slope_f};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      lk_valid  <= 1'b0;
      lk_addr   <= '0;
      lk_center <= '0;
    end else begin
      pend_q   <= in_valid;
      lk_valid <= pend_q;
      if (pend_q) begin
        lk_addr   <= addr_d;
        lk_center <= taps_q[HALF];
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(taps_q))
    else $error("window moved without a sample");

  assert_lkorder_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_valid) |-> $past(pend_q))
    else $error("lookup strobe without a pending sample");

endmodule

// File: rtl/ecomp_table.sv
module ecomp_table #(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  localparam int DEPTH = 2**AW;

  logic [CW-1:0] mem [DEPTH];

  // storage carries no reset; read returns the pre-write word on a collision
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> mem[$past(wr_addr)] == $past(wr_data))
    else $error("table write not stored");

endmodule

// File: rtl/ecomp_sum.sv
module ecomp_sum #(
  parameter int DW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] center,
  input  logic [CW-1:0] corr,
  input  logic          bypass,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  import ecomp_pkg::*;

  localparam int OMAX = 2**(DW-1) - 1;
  localparam int OMIN = -(2**(DW-1));

  int            sum_i;
  logic [DW-1:0] out_d;

  always_comb begin
    sum_i = int'($signed(center)) + int'($signed(corr));
    out_d = bypass ? center : DW'(clamp_int(sum_i, OMIN, OMAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= out_d;
      end
    end
  end

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(bypass)) |-> out_sample == $past(center))
    else $error("bypass altered sample");

  assert_nowrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(bypass) && !$past(center[DW-1]) && !$past(corr[CW-1]))
      |-> ($signed(out_sample) >= $signed($past(center))))
    else $error("positive sum wrapped");

  assert_nowrap_neg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(bypass) && $past(center[DW-1]) && $past(corr[CW-1]))
      |-> ($signed(out_sample) <= $signed($past(center))))
    else $error("negative sum wrapped");

endmodule

// File: rtl/lut_adc_corrector.sv
module lut_adc_corrector #(
  parameter int DW    = 12,
  parameter int HALF  = 2,
  parameter int AB    = 5,
  parameter int SB    = 5,
  parameter int SHIFT = 6,
  parameter int CW    = 8,
  localparam int AW   = AB + SB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic          bypass,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);

  logic          rst_m_q, rst_s_q;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic [DW-1:0] lk_center;
  logic          al_valid_q;
  logic [DW-1:0] al_center_q;
  logic [CW-1:0] corr;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  ecomp_slope #(.DW(DW), .HALF(HALF), .AB(AB), .SB(SB), .SHIFT(SHIFT)) u_slope (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_center (lk_center)
  );

  ecomp_table #(.AW(AW), .CW(CW)) u_table (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (lk_valid),
    .rd_addr (lk_addr),
    .rd_data (corr)
  );

  // raw sample held one more stage to match the table read
  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      al_valid_q  <= 1'b0;
      al_center_q <= '0;
    end else begin
      al_valid_q <= lk_valid;
      if (lk_valid) begin
        al_center_q <= lk_center;
      end
    end
  end

  ecomp_sum #(.DW(DW), .CW(CW)) u_sum (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .in_valid   (al_valid_q),
    .center     (al_center_q),
    .corr       (corr),
    .bypass     (bypass),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  assert_chain_R2: assert property (@(posedge clk) disable iff (!rst_s_q)
    al_valid_q |=> out_valid)
    else $error("aligned sample lost");

  assert_nospur_R2: assert property (@(posedge clk) disable iff (!rst_s_q)
    !al_valid_q |=> !out_valid)
    else $error("spurious output strobe");

  assert_reset_R1: assert property (@(posedge clk)
    !rst_s_q |-> (!out_valid && out_sample == '0))
    else $error("output active in reset");

endmodule

// File: tb/tb_lut_adc_corrector.sv
module tb_lut_adc_corrector;
  localparam int DW = 12;
  localparam int AW = 10;
  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  logic          bypass;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic          out_valid;
  logic [DW-1:0] out_sample;

  lut_adc_corrector dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .bypass(bypass), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  typedef struct { int due; int val; string tag; } exp_t;

  exp_t q[$];
  int   tbl[1024];
  int   hist[5];
  int   cyc   = 0;
  int   nchk  = 0;
  int   nfail = 0;
  bit   mon_on = 0;
  bit   done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int clampf(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // R4 / R5: slope index from the window
  function automatic int slope_idx();
    int d;
    d = 2 * (hist[1] - hist[3]) + (hist[0] - hist[4]);
    return clampf(d >>> 6, -16, 15);
  endfunction

  // R6: address from centre bits 11:7 and slope index
  function automatic int addr_of();
    return (((hist[2] & 12'hFFF) >> 7) << 5) | (slope_idx() & 31);
  endfunction

  function automatic int expect_out(bit byp);
    if (byp) return hist[2];
    return clampf(hist[2] + tbl[addr_of()], -2048, 2047);
  endfunction

  // output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R2 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R2 timing", cyc, e.due);
          check(e.tag, int'($signed(out_sample)), e.val);
        end
      end else if (q.size() > 0 && q[0].due == cyc) begin
        check("R2 missing out_valid", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  function automatic void push_sample(int x, string tag);
    exp_t e;
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    e.due = cyc + 4;
    e.val = expect_out(bypass);
    e.tag = tag;
    q.push_back(e);
  endfunction

  task automatic feed(int x, string tag);
    @(negedge clk);
    wr_en     = 1'b0;
    in_valid  = 1'b1;
    in_sample = DW'(x);
    push_sample(x, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      wr_en    = 1'b0;
    end
  endtask

  task automatic twrite(int a, int d);
    @(negedge clk);
    in_valid = 1'b0;
    wr_en    = 1'b1;
    wr_addr  = AW'(a);
    wr_data  = CW'(d);
    tbl[a]   = d;
  endtask

  // R9: write aimed at the lookup of one sample, off=1 earlier edge, off=2 same edge
  task automatic feed_collide(int x, int off);
    int a, d;
    int save[5];
    save = hist;
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    a = addr_of();
    hist = save;
    d = (tbl[a] >= 0) ? tbl[a] - 77 : tbl[a] + 77;
    if (off == 1) tbl[a] = d;
    feed(x, (off == 1) ? "R9 write before lookup" : "R9 write on lookup edge");
    if (off == 2) tbl[a] = d;
    for (int s = 1; s <= 2; s++) begin
      @(negedge clk);
      in_valid = 1'b0;
      wr_en    = (s == off);
      wr_addr  = AW'(a);
      wr_data  = CW'(d);
    end
    idle(1);
  endtask

  function automatic int rnd_range(int lo, int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int x, step;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 5; i++) hist[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; bypass = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check("R1 in reset valid", int'(out_valid), 0);
    check("R1 in reset data", int'(out_sample), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release valid", int'(out_valid), 0);
    check("R1 after release data", int'(out_sample), 0);
    mon_on = 1'b1;

    // R9: load the whole table
    for (int a = 0; a < 1024; a++) twrite(a, rnd_range(-128, 127));
    idle(2);

    // R7: full-range random codes with occasional gaps
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) idle(1);
      feed(rnd_range(-2048, 2047), "R7 random");
    end
    idle(6);

    // R5: ramps sweep the slope index across and past its clamp
    for (int r = 0; r < 24; r++) begin
      x = rnd_range(-2048, 2047);
      step = rnd_range(-200, 200);
      for (int i = 0; i < 30; i++) begin
        x = clampf(x + step, -2048, 2047);
        feed(x, "R5 ramp slope");
      end
    end
    idle(6);

    // R4 / R6: small wander exercises fine slope and centre bits
    x = 0;
    for (int i = 0; i < 400; i++) begin
      x = clampf(x + rnd_range(-40, 40), -2048, 2047);
      feed(x, "R4 R6 wander");
    end
    idle(6);

    // R3: long idle gaps must not disturb the window
    for (int i = 0; i < 40; i++) begin
      feed(rnd_range(-1500, 1500), "R3 gapped");
      idle(rnd_range(1, 9));
    end
    idle(6);

    // R8: bypass passes the aligned raw sample
    @(negedge clk); bypass = 1'b1;
    for (int i = 0; i < 150; i++) feed(rnd_range(-2048, 2047), "R8 bypass");
    idle(6);
    @(negedge clk); bypass = 1'b0;

    // R10: saturation at both rails, slope index 0
    twrite(480, 100);
    twrite(512, -100);
    for (int i = 0; i < 8; i++) feed(2047, "R10 upper rail");
    for (int i = 0; i < 8; i++) feed(-2048, "R10 lower rail");
    for (int i = 0; i < 8; i++) feed(2000, "R10 near upper");
    idle(6);

    // R9: write/lookup collision ordering
    for (int i = 0; i < 6; i++) begin
      feed(rnd_range(-1000, 1000), "R9 setup");
      idle(6);
      feed_collide(rnd_range(-1000, 1000), 1);
      idle(6);
      feed_collide(rnd_range(-1000, 1000), 2);
      idle(6);
    end

    idle(10);
    check("R2 all outputs delivered", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule